// File: doc/BRIEF.md
# Configurable Logic Cell

A single programmable logic cell. A 32-bit truth table drives a function generator over five inputs. Two flip-flops and two selectable outputs follow the generator. The cell has two modes. In download mode, a serial configuration stream fills the whole configuration memory one bit per accepted transfer. After the last bit, the cell enters configured mode and behaves as fixed logic until the next download or a global reset.

The configuration stream uses a valid/ready handshake. A bit transfers on a rising clock edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is high only while the cell is downloading, and is low in any cycle that `cfg_start` is asserted. The sender may hold `cfg_valid` low for any number of cycles. It must hold `cfg_bit` stable while `cfg_valid` is high and `cfg_ready` is low. `cfg_start`, `cfg_done`, the resets and the logic inputs are plain level signals.

Top module: `cfg_logic_cell`

## Requirements
- R1: While `grst_n` is low, and in the first cycle after it rises, `cfg_done` is 0, `cfg_ready` is 1, and `x` and `y` are 0.
- R2: While downloading, a bit is accepted on each rising edge with `cfg_valid` and `cfg_ready` both high. The k-th accepted bit (k from 0) becomes configuration bit k. The layout is: bits 31:0 truth table; bit 32 split mode; bit 33 QX takes the F output (else `din`); bit 34 QY takes the G output (else `din`); bits 36:35 X output select; bits 38:37 Y output select; bit 39 G-variable swap.
- R3: `cfg_done` rises on the edge that accepts the 40th bit. It stays high, with `cfg_ready` low, until `cfg_start` or a global reset. Bits offered while `cfg_done` is high change nothing.
- R4: `cfg_start` clears `cfg_done` on the next edge and restarts the download at bit 0. `cfg_ready` is low during the cycle that `cfg_start` is high.
- R5: While `cfg_done` is 0, `x` and `y` are 0 and both flip-flops are held cleared.
- R6: With bit 32 = 0, F = G = truth table bit at index {e,d,c,b,a}, where `fin[0]`=a … `fin[4]`=e.
- R7: With bit 32 = 1, F = truth table bit {0,d,c,b,a}. G = truth table bit {1,s,c,b,a}, where s is e if bit 39 is 1 and d otherwise.
- R8: With `ce` high and no reset, QX loads F (bit 33 = 1) or `din` (bit 33 = 0). QY loads G (bit 34 = 1) or `din` (bit 34 = 0).
- R9: With `ce` low, both flip-flops keep their value.
- R10: `lrst` high, or `grst_n` low, clears both flip-flops at once, whatever `ce` is. A global reset also returns the cell to download mode.
- R11: Output select codes are 0 = F, 1 = G, 2 = QX, 3 = QY. `x` and `y` are combinational from the current inputs and flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell and the configuration port |
| grst_n | input | 1 | Global asynchronous reset, active low |
| lrst | input | 1 | Local asynchronous flip-flop clear, active high |
| cfg_start | input | 1 | Begin a new download |
| cfg_valid | input | 1 | Configuration bit offered |
| cfg_ready | output | 1 | Cell can accept a configuration bit |
| cfg_bit | input | 1 | Configuration data bit |
| cfg_done | output | 1 | Configuration complete; cell is in configured mode |
| fin | input | 5 | Function variables a (bit 0) to e (bit 4) |
| din | input | 1 | Direct data input to the flip-flops |
| ce | input | 1 | Common flip-flop enable |
| x | output | 1 | Selected output X |
| y | output | 1 | Selected output Y |

## Verification
For each of sixteen configurations, the bench applies all 64 combinations of the five function inputs and `din`. Together these configurations cover every pairing of X and Y select codes and both function-generator forms. The full sweep separates the unified 5-input table from the split halves and from the swapped G variable. Random enable and occasional local reset during the sweep separate a load from a hold and from a clear that overrides the enable. Separate patterns test the download: gaps in the stream, a restart partway through, bits offered after completion, and a global reset during operation.

// File: rtl/clc_pkg.sv
package clc_pkg;
  localparam int LUT_IN    = 5;
  localparam int TT_BITS   = 1 << LUT_IN;
  localparam int CTRL_BITS = 8;
  localparam int CFG_BITS  = TT_BITS + CTRL_BITS;

  typedef enum logic [1:0] {
    OSEL_F  = 2'd0,
    OSEL_G  = 2'd1,
    OSEL_QX = 2'd2,
    OSEL_QY = 2'd3
  } osel_e;

  // Packed MSB first, so a cast of the raw memory lines up with the stream order
  typedef struct packed {
    logic                gswap;
    osel_e               ysel;
    osel_e               xsel;
    logic                qy_fn;
    logic                qx_fn;
    logic                split;
    logic [TT_BITS-1:0]  tt;
  } cell_cfg_t;
endpackage

// File: rtl/clc_cfg_loader.sv
module clc_cfg_loader
  import clc_pkg::*;
#(
  parameter int N = CFG_BITS
) (
  input  logic         clk,
  input  logic         grst_n,
  input  logic         start,
  input  logic         valid,
  input  logic         sbit,
  output logic         ready,
  output logic         done,
  output logic [N-1:0] mem
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;
  logic          take;

  assign ready = ~done & ~start;
  assign take  = valid & ready;

  always_ff @(posedge clk or negedge grst_n) begin
    if (!grst_n) begin
      mem  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (take) begin
      mem <= {sbit, mem[N-1:1]};
      if (cnt == LAST) begin
        cnt  <= '0;
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3
  last_bit_done_chk: assert property (@(posedge clk) disable iff (!grst_n)
    (take && cnt == LAST) |=> done);
  // R3
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!grst_n)
    (done && !start) |=> $stable(mem));
  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (!grst_n)
    start |=> (!done && cnt == '0));
endmodule

// File: rtl/clc_func_gen.sv
module clc_func_gen
  import clc_pkg::*;
#(
  parameter int K = LUT_IN
) (
  input  logic [(1<<K)-1:0] tt,
  input  logic              split,
  input  logic              gswap,
  input  logic [K-1:0]      v,
  output logic              f,
  output logic              g
);
  logic [K-1:0] f_idx, g_idx;

  always_comb begin
    if (split) begin
      // Top index bit chooses the half; G may take the last variable in place of the next-to-last
      f_idx = {1'b0, v[K-2:0]};
      g_idx = {1'b1, (gswap ? v[K-1] : v[K-2]), v[K-3:0]};
    end else begin
      f_idx = v;
      g_idx = v;
    end
  end

  assign f = tt[f_idx];
  assign g = tt[g_idx];
endmodule

// File: rtl/clc_state_bit.sv
module clc_state_bit (
  input  logic clk,
  input  logic clr,
  input  logic ce,
  input  logic sel_fn,
  input  logic din,
  input  logic fn,
  output logic q
);
  logic d;
  assign d = sel_fn ? fn : din;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)     q <= 1'b0;
    else if (ce) q <= d;
  end

  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (clr)
    !ce |=> $stable(q));
  // R8
  load_when_on_chk: assert property (@(posedge clk) disable iff (clr)
    ce |=> (q == $past(sel_fn ? fn : din)));
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import clc_pkg::*;
(
  input  logic       clk,
  input  logic       grst_n,
  input  logic       lrst,
  input  logic       cfg_start,
  input  logic       cfg_valid,
  output logic       cfg_ready,
  input  logic       cfg_bit,
  output logic       cfg_done,
  input  logic [4:0] fin,
  input  logic       din,
  input  logic       ce,
  output logic       x,
  output logic       y
);
  logic [CFG_BITS-1:0] raw;
  cell_cfg_t           cfg;
  logic                f, g, ff_clr;
  logic [1:0]          q_w, fn_w, sel_w;

  clc_cfg_loader #(.N(CFG_BITS)) u_load (
    .clk   (clk),
    .grst_n(grst_n),
    .start (cfg_start),
    .valid (cfg_valid),
    .sbit  (cfg_bit),
    .ready (cfg_ready),
    .done  (cfg_done),
    .mem   (raw)
  );

  assign cfg = cell_cfg_t'(raw);

  clc_func_gen #(.K(LUT_IN)) u_fg (
    .tt   (cfg.tt),
    .split(cfg.split),
    .gswap(cfg.gswap),
    .v    (fin),
    .f    (f),
    .g    (g)
  );

  // Flip-flops are held clear unless configured
  assign ff_clr = lrst | ~grst_n | ~cfg_done;
  assign fn_w   = {g, f};
  assign sel_w  = {cfg.qy_fn, cfg.qx_fn};

  for (genvar i = 0; i < 2; i++) begin : g_st
    clc_state_bit u_st (
      .clk   (clk),
      .clr   (ff_clr),
      .ce    (ce),
      .sel_fn(sel_w[i]),
      .din   (din),
      .fn    (fn_w[i]),
      .q     (q_w[i])
    );
  end

  function automatic logic pick(osel_e s, logic vf, logic vg, logic vqx, logic vqy);
    case (s)
      OSEL_F:  return vf;
      OSEL_G:  return vg;
      OSEL_QX: return vqx;
      default: return vqy;
    endcase
  endfunction

  assign x = cfg_done & pick(cfg.xsel, f, g, q_w[0], q_w[1]);
  assign y = cfg_done & pick(cfg.ysel, f, g, q_w[0], q_w[1]);

  // R5
  quiet_in_download_chk: assert property (@(posedge clk) disable iff (!grst_n)
    !cfg_done |-> (x == 1'b0 && y == 1'b0 && q_w == 2'b00));
  // R6
  unified_fg_chk: assert property (@(posedge clk) disable iff (!grst_n)
    (cfg_done && !cfg.split) |-> (f == g));
  // R10
  local_clear_chk: assert property (@(posedge clk) disable iff (!grst_n)
    lrst |-> (q_w == 2'b00));
endmodule

// File: tb/cfg_logic_cell_test.sv
module cfg_logic_cell_test;
  logic       clk = 1'b0;
  logic       grst_n, lrst, cfg_start, cfg_valid, cfg_bit, din, ce;
  logic [4:0] fin;
  logic       cfg_ready, cfg_done, x, y;

  int nchk = 0;
  int nfail = 0;
  bit ended = 0;

  logic [39:0] cur;
  logic        mqx, mqy;
  string       qx_tag, qy_tag;

  always #5 clk = ~clk;

  cfg_logic_cell uut (
    .clk(clk), .grst_n(grst_n), .lrst(lrst), .cfg_start(cfg_start),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .fin(fin), .din(din), .ce(ce), .x(x), .y(y)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0b expected %0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] model_fg(logic [39:0] c, logic [4:0] v);
    logic [4:0] fi, gi;
    if (c[32]) begin
      fi = {1'b0, v[3:0]};
      gi = {1'b1, (c[39] ? v[4] : v[3]), v[2:0]};
    end else begin
      fi = v;
      gi = v;
    end
    return {c[gi], c[fi]};
  endfunction

  function automatic logic pick(logic [1:0] s, logic [1:0] fg, logic qa, logic qb);
    case (s)
      2'd0: return fg[0];
      2'd1: return fg[1];
      2'd2: return qa;
      default: return qb;
    endcase
  endfunction

  function automatic string out_tag(logic [1:0] s);
    if (s == 2'd2) return qx_tag;
    if (s == 2'd3) return qy_tag;
    return cur[32] ? "R7" : "R6";
  endfunction

  // Full download of c; optional idle gaps in the stream
  task automatic load_cfg(input logic [39:0] c, input bit gaps);
    @(negedge clk);
    cfg_start = 1'b1; cfg_valid = 1'b1; cfg_bit = ~c[0];
    #1 chk("R4 ready low on start", cfg_ready, 1'b0);
    @(negedge clk);
    cfg_start = 1'b0;
    #1 chk("R4 done cleared", cfg_done, 1'b0);
    for (int i = 0; i < 40; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        cfg_valid = 1'b0;
        fin = 5'($urandom); din = 1'($urandom); ce = 1'b1;
        #1;
        chk("R5 x quiet", x, 1'b0);
        chk("R5 y quiet", y, 1'b0);
        @(negedge clk);
      end
      cfg_valid = 1'b1; cfg_bit = c[i];
      fin = 5'($urandom);
      #1;
      chk("R2 ready in download", cfg_ready, 1'b1);
      chk("R3 done low before last bit", cfg_done, 1'b0);
      chk("R5 x quiet", x, 1'b0);
      @(negedge clk);
    end
    cfg_valid = 1'b0;
    #1;
    chk("R3 done after last bit", cfg_done, 1'b1);
    chk("R3 ready low when done", cfg_ready, 1'b0);
    cur = c; mqx = 1'b0; mqy = 1'b0;
    qx_tag = "R5"; qy_tag = "R5";
  endtask

  // One vector: drive at negedge, compare, advance model over the next edge
  task automatic run_vec(input logic [4:0] v, input logic d, input logic e, input logic r);
    logic [1:0] fg;
    fin = v; din = d; ce = e; lrst = r;
    #1;
    if (r) begin mqx = 1'b0; mqy = 1'b0; qx_tag = "R10"; qy_tag = "R10"; end
    fg = model_fg(cur, v);
    chk({out_tag(cur[36:35]), "/R11 x"}, x, pick(cur[36:35], fg, mqx, mqy));
    chk({out_tag(cur[38:37]), "/R11 y"}, y, pick(cur[38:37], fg, mqx, mqy));
    if (!r) begin
      if (e) begin
        mqx = cur[33] ? fg[0] : d; mqy = cur[34] ? fg[1] : d;
        qx_tag = "R8"; qy_tag = "R8";
      end else begin
        qx_tag = "R9"; qy_tag = "R9";
      end
    end
    @(negedge clk);
  endtask

  task automatic sweep();
    for (int i = 0; i < 64; i++)
      run_vec(5'(i), i[5], 1'($urandom), ($urandom % 16) == 0);
    lrst = 1'b0;
  endtask

  initial begin
    grst_n = 1'b0; lrst = 1'b0; cfg_start = 1'b0; cfg_valid = 1'b0;
    cfg_bit = 1'b0; din = 1'b0; ce = 1'b0; fin = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 done at reset", cfg_done, 1'b0);
    chk("R1 ready at reset", cfg_ready, 1'b1);
    chk("R1 x at reset", x, 1'b0);
    chk("R1 y at reset", y, 1'b0);
    @(negedge clk);
    grst_n = 1'b1;
    #1 chk("R1 done after release", cfg_done, 1'b0);

    for (int k = 0; k < 16; k++) begin
      logic [39:0] c;
      c = {8'($urandom), 32'($urandom)};
      c[36:35] = 2'(k);
      c[38:37] = 2'(k >> 2);
      c[32]    = k[0] ^ k[2];
      c[39]    = k[1] ^ k[3];
      load_cfg(c, k[0]);
      sweep();
      if (k == 5) begin
        // R3: bits offered after completion are ignored
        for (int i = 0; i < 40; i++) begin
          cfg_valid = 1'b1; cfg_bit = ~c[i];
          #1 chk("R3 ready stays low", cfg_ready, 1'b0);
          @(negedge clk);
        end
        cfg_valid = 1'b0;
        sweep();
      end
    end

    // R4: restart partway through a download
    @(negedge clk);
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      cfg_valid = 1'b1; cfg_bit = 1'($urandom);
      @(negedge clk);
    end
    cfg_valid = 1'b0;
    load_cfg({8'b0101_1011, 32'($urandom)}, 1'b0);
    sweep();

    // R10: global reset during operation clears state and configuration
    run_vec(5'd0, 1'b1, 1'b1, 1'b0);
    grst_n = 1'b0;
    #1;
    chk("R10 done cleared by global reset", cfg_done, 1'b0);
    chk("R10 x cleared by global reset", x, 1'b0);
    chk("R10 y cleared by global reset", y, 1'b0);
    @(negedge clk);
    grst_n = 1'b1;
    load_cfg({8'b0111_0110, 32'($urandom)}, 1'b1);
    sweep();

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule